// File: doc/BRIEF.md
# Data Bus Grant Qualifier

This block sits on the master side of a split address/data bus that carries no shared data-bus-busy line. It decides in which cycle the master may begin a data tenure. Every data bus grant that arrives is held in a latch, whether or not the master has an address tenure outstanding. Each cycle the held grant is qualified against address retry, data retry and the master's own busy state. A data tenure starts when a qualified grant and a pending tenure request are present in the same cycle.

The master keeps its own busy flag in place of the missing shared signal. The flag sets when a tenure starts. Transfer acknowledges are counted to find the last beat of the cache-line burst. The flag then stays set for one more drain cycle, which gives the required idle cycle before the next tenure can begin. The bus width comes from a strap pin sampled while reset is held, and it fixes the burst length. An elaboration option masks incoming grants until the master has driven its own transfer start, so a grant parked on the master cannot pair with a later, unrelated request.

Top module: `data_grant_qualifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `tenure_start`, `data_busy` and `tenure_done` are 0.
- R2: `bus_wide` holds the inverse of `strap_wide_n` as sampled on the last clock edge with `rst` high. A value of 1 (strap low) selects 64-bit mode with 4-beat bursts; 0 (strap high) selects 32-bit mode with 8-beat bursts. Changes on the strap after reset release have no effect.
- R3: A grant (`dgrant_n` low) in any cycle is latched, even with no tenure pending. A later cycle with `tenure_pending` high starts a tenure without a new grant.
- R4: If a qualified grant and `tenure_pending` coincide in cycle t, then `tenure_start` is 1 for exactly one cycle, t+1, and `data_busy` rises in t+1.
- R5: In any cycle with `aretry_n` or `dretry_n` low, no tenure is started. The latched grant is kept and can start a tenure once the retries are released.
- R6: `tenure_done` is 1 and `data_busy` is still 1 in the cycle after the final acknowledge (`tack_n` low) of the burst. `data_busy` is 0 in the cycle after that.
- R7: No grant is qualified while `data_busy` is 1. A grant or request held over the end of a tenure produces `tenure_start` no earlier than two cycles after `tenure_done`.
- R8: With `GATE_PARKED`=1, a grant is accepted only in a cycle with `tstart_n` low or after such a cycle. The arming is cleared when a tenure starts, so grants before the master's own transfer start are discarded.
- R9: Transfer acknowledges outside a tenure are not counted. A tenure always needs the full burst of acknowledges.
- R10: A latched grant is consumed by the tenure it starts. A later pending request needs a new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| strap_wide_n | input | 1 | Width strap, low selects 64-bit bus |
| dgrant_n | input | 1 | Data bus grant, active low |
| aretry_n | input | 1 | Address retry, active low |
| dretry_n | input | 1 | Data retry, active low |
| tstart_n | input | 1 | This master's transfer start, active low |
| tack_n | input | 1 | Transfer acknowledge, active low |
| tenure_pending | input | 1 | A data tenure is waiting to run |
| tenure_start | output | 1 | One-cycle pulse in the first cycle of a tenure |
| data_busy | output | 1 | Internal data busy flag, held through the drain cycle |
| tenure_done | output | 1 | One-cycle pulse in the drain cycle after the final acknowledge |
| bus_wide | output | 1 | Latched width mode, 1 for 64-bit |

## Verification
All results are registered once. A start qualified in cycle t shows on `tenure_start` and `data_busy` in t+1. The final acknowledge in cycle u shows `tenure_done` in u+1 and a low `data_busy` in u+2. A grant held across the tenure end can therefore produce `tenure_start` no earlier than u+3. The bench drives inputs just after a rising edge and reads the outputs just after the next edge, so each observation matches the inputs of exactly one preceding cycle. A cycle-stepped reference model, built from the requirements and advanced on the same edges, is compared every cycle alongside the directed checks. Both the ungated and the gated variant run on identical stimulus.

// File: rtl/dgq_pkg.sv
package dgq_pkg;

  typedef enum logic [1:0] {
    TEN_IDLE  = 2'd0,
    TEN_XFER  = 2'd1,
    TEN_DRAIN = 2'd2
  } ten_state_e;

  function automatic int beats_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dgq_width_strap.sv
module dgq_width_strap #(
  parameter int BEATS_WIDE   = 4,
  parameter int BEATS_NARROW = 8,
  parameter int CNT_W        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_wide_n,
  output logic             wide_o,
  output logic [CNT_W-1:0] last_idx_o
);

  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(BEATS_WIDE - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(BEATS_NARROW - 1);

  logic             wide_q;
  logic [CNT_W-1:0] last_q;

  // The strap is followed while reset is held; the final value is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= ~strap_wide_n;
      last_q <= (~strap_wide_n) ? LAST_WIDE : LAST_NARROW;
    end
  end

  assign wide_o     = wide_q;
  assign last_idx_o = last_q;

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(wide_q) && $stable(last_q))); // R2

endmodule

// File: rtl/dgq_grant_gate.sv
module dgq_grant_gate #(
  parameter bit GATE_PARKED = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic addr_retry,
  input  logic data_retry,
  input  logic own_start,
  input  logic pending,
  input  logic idle,
  output logic take_o
);

  logic held_q;
  logic armed_q;
  logic accept;
  logic qualified;
  logic take;

  // Grants are masked until this master has issued its own transfer start.
  assign accept    = grant & ((GATE_PARKED != 1'b0) ? (armed_q | own_start) : 1'b1);
  assign qualified = (held_q | accept) & ~addr_retry & ~data_retry & idle;
  assign take      = qualified & pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      held_q  <= take ? 1'b0 : (held_q | accept);
      armed_q <= own_start | (armed_q & ~take);
    end
  end

  assign take_o = take;

  AST_TAKE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (idle && pending)); // R7

endmodule

// File: rtl/dgq_tenure_fsm.sv
module dgq_tenure_fsm
  import dgq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             ack,
  input  logic [CNT_W-1:0] last_idx,
  output logic             idle_o,
  output logic             start_o,
  output logic             busy_o,
  output logic             done_o
);

  ten_state_e       state_q;
  logic [CNT_W-1:0] beat_q;
  logic             start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TEN_IDLE;
      beat_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= take;
      unique case (state_q)
        TEN_IDLE: begin
          if (take) begin
            state_q <= TEN_XFER;
            beat_q  <= '0;
          end
        end
        TEN_XFER: begin
          if (ack) begin
            if (beat_q == last_idx) begin
              state_q <= TEN_DRAIN;
              beat_q  <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        TEN_DRAIN: state_q <= TEN_IDLE;
        default:   state_q <= TEN_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == TEN_IDLE);
  assign busy_o  = (state_q != TEN_IDLE);
  assign done_o  = (state_q == TEN_DRAIN);
  assign start_o = start_q;

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == TEN_XFER) |-> (beat_q <= last_idx)); // R6

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state_q == TEN_IDLE) |-> (beat_q == '0)); // R9

endmodule

// File: rtl/data_grant_qualifier.sv
module data_grant_qualifier
  import dgq_pkg::*;
#(
  parameter int BEATS_WIDE   = 4,
  parameter int BEATS_NARROW = 8,
  parameter bit GATE_PARKED  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic strap_wide_n,
  input  logic dgrant_n,
  input  logic aretry_n,
  input  logic dretry_n,
  input  logic tstart_n,
  input  logic tack_n,
  input  logic tenure_pending,
  output logic tenure_start,
  output logic data_busy,
  output logic tenure_done,
  output logic bus_wide
);

  localparam int MAX_BEATS = beats_max(BEATS_WIDE, BEATS_NARROW);
  localparam int CNT_W     = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  logic             grant, addr_retry, data_retry, own_start, ack;
  logic [CNT_W-1:0] last_idx;
  logic             idle, take;

  assign grant      = ~dgrant_n;
  assign addr_retry = ~aretry_n;
  assign data_retry = ~dretry_n;
  assign own_start  = ~tstart_n;
  assign ack        = ~tack_n;

  dgq_width_strap #(
    .BEATS_WIDE  (BEATS_WIDE),
    .BEATS_NARROW(BEATS_NARROW),
    .CNT_W       (CNT_W)
  ) u_strap (
    .clk         (clk),
    .rst         (rst),
    .strap_wide_n(strap_wide_n),
    .wide_o      (bus_wide),
    .last_idx_o  (last_idx)
  );

  dgq_grant_gate #(
    .GATE_PARKED(GATE_PARKED)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .grant     (grant),
    .addr_retry(addr_retry),
    .data_retry(data_retry),
    .own_start (own_start),
    .pending   (tenure_pending),
    .idle      (idle),
    .take_o    (take)
  );

  dgq_tenure_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .ack     (ack),
    .last_idx(last_idx),
    .idle_o  (idle),
    .start_o (tenure_start),
    .busy_o  (data_busy),
    .done_o  (tenure_done)
  );

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    tenure_start |=> !tenure_start); // R4

  AST_BUSY_RISES_WITH_START: assert property (@(posedge clk) disable iff (rst)
    $rose(data_busy) |-> tenure_start); // R4

  AST_RETRY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!aretry_n || !dretry_n) |=> !tenure_start); // R5

  AST_DONE_THEN_FREE: assert property (@(posedge clk) disable iff (rst)
    tenure_done |=> !data_busy); // R6

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    data_busy |=> !tenure_start); // R7

endmodule

// File: tb/test_data_grant_qualifier.sv
module test_data_grant_qualifier;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_wide_n = 1'b0;
  logic dgrant_n = 1'b1, aretry_n = 1'b1, dretry_n = 1'b1;
  logic tstart_n = 1'b1, tack_n = 1'b1, tenure_pending = 1'b0;

  logic st0, bz0, dn0, wd0;
  logic st1, bz1, dn1, wd1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  data_grant_qualifier i_data_grant_qualifier (
    .clk(clk), .rst(rst), .strap_wide_n(strap_wide_n), .dgrant_n(dgrant_n),
    .aretry_n(aretry_n), .dretry_n(dretry_n), .tstart_n(tstart_n), .tack_n(tack_n),
    .tenure_pending(tenure_pending), .tenure_start(st0), .data_busy(bz0),
    .tenure_done(dn0), .bus_wide(wd0));

  data_grant_qualifier #(.GATE_PARKED(1'b1)) i_data_grant_qualifier_gated (
    .clk(clk), .rst(rst), .strap_wide_n(strap_wide_n), .dgrant_n(dgrant_n),
    .aretry_n(aretry_n), .dretry_n(dretry_n), .tstart_n(tstart_n), .tack_n(tack_n),
    .tenure_pending(tenure_pending), .tenure_start(st1), .data_busy(bz1),
    .tenure_done(dn1), .bus_wide(wd1));

  // Reference model built from the requirements, one step per bus cycle.
  typedef struct {
    bit held; bit armed; int st; int cnt; bit start; bit wide;
  } ref_t;

  ref_t m0, m1;

  function automatic ref_t ref_step(ref_t m, bit gate);
    ref_t n = m;
    bit g, acc, take;
    int len;
    if (rst) begin
      n.held = 0; n.armed = 0; n.st = 0; n.cnt = 0; n.start = 0; n.wide = !strap_wide_n;
      return n;
    end
    g    = !dgrant_n;
    acc  = g && (!gate || m.armed || !tstart_n);
    take = (m.held || acc) && aretry_n && dretry_n && (m.st == 0) && tenure_pending;
    len  = m.wide ? 4 : 8;
    n.held  = take ? 1'b0 : (m.held || acc);
    n.armed = !tstart_n || (m.armed && !take);
    n.start = take;
    if (m.st == 0) begin
      if (take) begin n.st = 1; n.cnt = 0; end
    end else if (m.st == 1) begin
      if (!tack_n) begin
        if (m.cnt == len - 1) begin n.st = 2; n.cnt = 0; end
        else n.cnt = m.cnt + 1;
      end
    end else begin
      n.st = 0;
    end
    return n;
  endfunction

  always @(posedge clk) begin
    m0 = ref_step(m0, 1'b0);
    m1 = ref_step(m1, 1'b1);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pack(bit s, bit b, bit d, bit w);
    return {28'd0, s, b, d, w};
  endfunction

  task automatic cmp_model;
    int a0 = pack(st0, bz0, dn0, wd0);
    int e0 = pack(m0.start, m0.st != 0, m0.st == 2, m0.wide);
    int a1 = pack(st1, bz1, dn1, wd1);
    int e1 = pack(m1.start, m1.st != 0, m1.st == 2, m1.wide);
    check(a0 == e0, "R4 R6 model ungated {start,busy,done,wide}", a0, e0);
    check(a1 == e1, "R8 model gated {start,busy,done,wide}", a1, e1);
  endtask

  // Drive one cycle of active-high stimulus, then observe just after the edge.
  task automatic cyc(input bit g, input bit ar, input bit dr, input bit ts,
                     input bit ta, input bit pend);
    dgrant_n = !g; aretry_n = !ar; dretry_n = !dr; tstart_n = !ts;
    tack_n = !ta; tenure_pending = pend;
    @(posedge clk); #1;
    if (!rst) cmp_model();
  endtask

  task automatic do_reset(input bit strap_n);
    rst = 1'b1; strap_wide_n = strap_n;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 4) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
          ($urandom % 7) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C01));
    do_reset(1'b0);
    // R1 reset state
    cyc(0, 0, 0, 0, 0, 0);
    check(st0 == 0 && bz0 == 0 && dn0 == 0, "R1 outputs after reset", pack(st0, bz0, dn0, 0), 0);
    check(wd0 == 1, "R2 strap low gives 64-bit", wd0, 1);
    strap_wide_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0);
    check(wd0 == 1, "R2 strap change after reset ignored", wd0, 1);

    // R3 parked grant latched with nothing pending
    cyc(1, 0, 0, 0, 0, 0);
    check(st0 == 0, "R3 no start without pending", st0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    check(st0 == 1 && bz0 == 1, "R3 R4 latched grant starts tenure", pack(st0, bz0, 0, 0), pack(1, 1, 0, 0));
    check(st1 == 0, "R8 gated variant drops grant before own start", st1, 0);
    cyc(0, 0, 0, 0, 0, 0);
    check(st0 == 0 && bz0 == 1, "R4 start is one pulse", pack(st0, bz0, 0, 0), pack(0, 1, 0, 0));
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0);
    check(dn0 == 0 && bz0 == 1, "R6 not done before final beat", pack(0, bz0, dn0, 0), pack(0, 1, 0, 0));
    cyc(0, 0, 0, 0, 1, 0);
    check(dn0 == 1 && bz0 == 1, "R6 done with busy in drain cycle", pack(0, bz0, dn0, 0), pack(0, 1, 1, 0));
    cyc(0, 0, 0, 0, 0, 0);
    check(dn0 == 0 && bz0 == 0, "R6 busy low after drain", pack(0, bz0, dn0, 0), 0);

    // R10 grant consumed
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    check(st0 == 0 && bz0 == 0, "R10 no second tenure without new grant", pack(st0, bz0, 0, 0), 0);

    // R5 retries block, grant kept; R8 arm by own start
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 0, 1);
    check(st0 == 0 && st1 == 0, "R5 address retry blocks start", pack(st0, st1, 0, 0), 0);
    cyc(0, 0, 1, 0, 0, 1);
    check(st0 == 0 && st1 == 0, "R5 data retry blocks start", pack(st0, st1, 0, 0), 0);
    cyc(0, 0, 0, 0, 0, 1);
    check(st0 == 1, "R5 held grant starts after retry", st0, 1);
    check(st1 == 1, "R8 grant after own start accepted", st1, 1);

    // R7 grant and request held across the tenure end
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 1, 1);
    check(st0 == 0, "R7 no start while busy", st0, 0);
    cyc(1, 0, 0, 0, 1, 1);
    check(dn0 == 1, "R7 final beat reached", dn0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    check(st0 == 0 && bz0 == 0, "R7 no start in cycle after drain", pack(st0, bz0, 0, 0), 0);
    cyc(0, 0, 0, 0, 0, 1);
    check(st0 == 1, "R7 start two cycles after done", st0, 1);
    check(st1 == 0, "R8 arming cleared by previous tenure", st1, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // R9 stray acknowledges while idle
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0);
    check(bz0 == 0 && bz1 == 0, "R9 idle acks do not start", pack(bz0, bz1, 0, 0), 0);
    cyc(1, 0, 0, 1, 0, 1);
    check(st0 == 1 && st1 == 1, "R8 grant with own start same cycle", pack(st0, st1, 0, 0), pack(1, 1, 0, 0));
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0);
    check(dn0 == 0, "R9 burst still needs full count", dn0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    check(dn0 == 1, "R9 done on fourth counted beat", dn0, 1);
    cyc(0, 0, 0, 0, 0, 0);

    rand_run(1500);

    // R2 narrow mode: 8-beat bursts
    do_reset(1'b1);
    cyc(0, 0, 0, 0, 0, 0);
    check(wd0 == 0, "R2 strap high gives 32-bit", wd0, 0);
    cyc(1, 0, 0, 1, 0, 1);
    check(st0 == 1, "R2 start in narrow mode", st0, 1);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0, 1, 0);
    check(dn0 == 0 && bz0 == 1, "R2 seven beats not enough", pack(0, bz0, dn0, 0), pack(0, 1, 0, 0));
    cyc(0, 0, 0, 0, 1, 0);
    check(dn0 == 1, "R2 done after eighth beat", dn0, 1);
    cyc(0, 0, 0, 0, 0, 0);

    rand_run(1500);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule